// File: doc/BRIEF.md
# Edge-Triggered Line Interrupt and Event Controller

This block watches a set of asynchronous input lines, 19 by default. For each line it can detect a rising edge, a falling edge, or both. A detected edge, or a request that software raises, becomes two kinds of output. The first is a sticky interrupt request for the CPU's interrupt controller. The second is a single-clock event pulse that other on-chip peripherals can use to start work with no software involved.

Every line has the same path. First a two-flop synchronizer brings the input into the clock domain. An edge comparator then checks the synchronized value against its value one clock earlier. Its hit is merged with a one-shot software request, and the merged request sets a per-line pending latch. The pending latch, gated by an interrupt mask, drives the interrupt output. In parallel, the merged request is gated by a separate event mask and fed to a per-line pulse state machine.

The pulse state machine has three states:
- `EV_IDLE`: waits for a request.
- `EV_FIRE`: the only state that drives the pulse.
- `EV_HOLD`: waits for the request to drop.

It has these transitions:
- `arm`: `EV_IDLE` to `EV_FIRE`, on a request.
- `rest`: `EV_FIRE` to `EV_IDLE`, when the request is gone.
- `stay`: `EV_FIRE` to `EV_HOLD`, when the request persists.
- `release`: `EV_HOLD` to `EV_IDLE`, when the request drops.

All six per-line registers sit behind a plain write strobe and a combinational read mux.

Top module: `lec_top`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` and `evt_pulse_o` are all 0.
- R2: Address 0 holds the rising-edge select bits. When a line's bit is 1, a 0-to-1 change on its input sets that line's pending bit. The change is held stable from one falling clock edge, and the pending bit is set on the third rising clock edge after that.
- R3: Address 1 holds the falling-edge select bits. When a line's bit is 1, a 1-to-0 change on its input sets the pending bit with the same latency as R2. With both select bits set, either edge sets it.
- R4: A line with neither select bit set never becomes pending from its input, whichever way the input moves.
- R5: Writing a 1 to a bit at address 2 that currently holds 0 stores the 1 and raises exactly one request on that line, on the clock edge that takes the write. Writing 1 again while the bit is still 1 raises no new request. Writing 0 has no effect.
- R6: Address 3 reads the pending bits. Writing 1 to a bit clears that pending bit, and also clears the same bit at address 2. Writing 0 leaves the bit unchanged.
- R7: If a request on a line arrives in the same clock as a write that clears its pending bit, the pending bit stays set.
- R8: Address 4 holds the interrupt mask. Each `irq_o` bit is high exactly when that line's pending bit and mask bit are both 1. A pending line whose mask is 0 stays pending.
- R9: Address 5 holds the event mask. Each request on a line whose event mask bit is 1 gives exactly one `evt_pulse_o` pulse, one clock wide, in the cycle after the request. The pulse does not depend on the pending bit or on the interrupt mask. A line whose event mask bit is 0 gives no pulse.
- R10: Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 19 | Asynchronous external lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 19 | Write data, one bit per line |
| reg_rdata | output | 19 | Read data for `reg_addr`, combinational |
| irq_o | output | 19 | Masked pending interrupt requests |
| evt_pulse_o | output | 19 | Single-cycle event pulses |

## Verification
Each result has a fixed latency, counted in rising clock edges:
- An input edge shows up in the pending bit, on `irq_o` and on `evt_pulse_o` three edges after the line changes. The edges are one synchronizer stage, one more synchronizer stage, and the pending or pulse-state register.
- A software trigger, a pending clear and a mask write take effect one edge after the write.
- An event pulse is gone one edge after it appears.

The bench changes inputs on falling edges, counts rising edges to the due cycle, and samples on the following falling edge. It checks the pulse both in its due cycle and in the next one. This makes both an early and a late result count as a mismatch.

// File: rtl/lec_pkg.sv
package lec_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_RISE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_FALL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_SWTRG = 3'd2;
    localparam logic [ADDR_W-1:0] A_PEND  = 3'd3;
    localparam logic [ADDR_W-1:0] A_IMASK = 3'd4;
    localparam logic [ADDR_W-1:0] A_EMASK = 3'd5;

    typedef enum logic [1:0] {
        EV_IDLE = 2'd0,
        EV_FIRE = 2'd1,
        EV_HOLD = 2'd2
    } ev_state_t;
endpackage

// File: rtl/lec_sync.sv
module lec_sync #(
    parameter int N      = 19,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] prev_o
);
    logic [N-1:0] chain [STAGES];
    logic [N-1:0] prev_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain[STAGES-1];
    end

    assign sync_o = chain[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/lec_edge.sv
module lec_edge #(
    parameter int N = 19
) (
    input  logic [N-1:0] now_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] rise_en_i,
    input  logic [N-1:0] fall_en_i,
    output logic [N-1:0] hit_o
);
    logic [N-1:0] went_up;
    logic [N-1:0] went_down;

    always_comb begin
        went_up   = now_i & ~prev_i;
        went_down = ~now_i & prev_i;
        hit_o     = (went_up & rise_en_i) | (went_down & fall_en_i);
    end
endmodule

// File: rtl/lec_regfile.sv
module lec_regfile
    import lec_pkg::*;
#(
    parameter int N = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      wdata_i,
    input  logic [N-1:0]      req_i,
    output logic [N-1:0]      rdata_o,
    output logic [N-1:0]      rise_o,
    output logic [N-1:0]      fall_o,
    output logic [N-1:0]      imask_o,
    output logic [N-1:0]      emask_o,
    output logic [N-1:0]      pend_o,
    output logic [N-1:0]      sw_pulse_o,
    output logic [N-1:0]      clr_o
);
    logic [N-1:0] rise_q, fall_q, sw_q, pend_q, imask_q, emask_q;
    logic         w_rise, w_fall, w_sw, w_pend, w_imask, w_emask;

    always_comb begin
        w_rise     = we_i && (addr_i == A_RISE);
        w_fall     = we_i && (addr_i == A_FALL);
        w_sw       = we_i && (addr_i == A_SWTRG);
        w_pend     = we_i && (addr_i == A_PEND);
        w_imask    = we_i && (addr_i == A_IMASK);
        w_emask    = we_i && (addr_i == A_EMASK);
        sw_pulse_o = w_sw ? (wdata_i & ~sw_q) : '0;
        clr_o      = w_pend ? wdata_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q  <= '0;
            fall_q  <= '0;
            imask_q <= '0;
            emask_q <= '0;
        end else begin
            if (w_rise)  rise_q  <= wdata_i;
            if (w_fall)  fall_q  <= wdata_i;
            if (w_imask) imask_q <= wdata_i;
            if (w_emask) emask_q <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q   <= '0;
            pend_q <= '0;
        end else begin
            sw_q   <= (sw_q | sw_pulse_o) & ~clr_o;
            pend_q <= (pend_q & ~clr_o) | req_i;
        end
    end

    always_comb begin
        case (addr_i)
            A_RISE:  rdata_o = rise_q;
            A_FALL:  rdata_o = fall_q;
            A_SWTRG: rdata_o = sw_q;
            A_PEND:  rdata_o = pend_q;
            A_IMASK: rdata_o = imask_q;
            A_EMASK: rdata_o = emask_q;
            default: rdata_o = '0;
        endcase
    end

    assign rise_o  = rise_q;
    assign fall_o  = fall_q;
    assign imask_o = imask_q;
    assign emask_o = emask_q;
    assign pend_o  = pend_q;
endmodule

// File: rtl/lec_pulse.sv
module lec_pulse
    import lec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pulse_o
);
    ev_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE: if (req_i)  state_d = EV_FIRE;
            EV_FIRE: state_d = req_i ? EV_HOLD : EV_IDLE;
            EV_HOLD: if (!req_i) state_d = EV_IDLE;
            default: state_d = EV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pulse_o = (state_q == EV_FIRE);
    end
endmodule

// File: rtl/lec_top.sv
module lec_top
    import lec_pkg::*;
#(
    parameter int N = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      line_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N-1:0]      reg_wdata,
    output logic [N-1:0]      reg_rdata,
    output logic [N-1:0]      irq_o,
    output logic [N-1:0]      evt_pulse_o
);
    logic [N-1:0] s_now, s_prev, edge_hit;
    logic [N-1:0] rise_q, fall_q, imask_q, emask_q, pend_q;
    logic [N-1:0] sw_pulse, clr_vec, req_vec, evt_req;

    lec_sync #(.N(N), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_i),
        .sync_o  (s_now),
        .prev_o  (s_prev)
    );

    lec_edge #(.N(N)) u_edge (
        .now_i     (s_now),
        .prev_i    (s_prev),
        .rise_en_i (rise_q),
        .fall_en_i (fall_q),
        .hit_o     (edge_hit)
    );

    lec_regfile #(.N(N)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .req_i      (req_vec),
        .rdata_o    (reg_rdata),
        .rise_o     (rise_q),
        .fall_o     (fall_q),
        .imask_o    (imask_q),
        .emask_o    (emask_q),
        .pend_o     (pend_q),
        .sw_pulse_o (sw_pulse),
        .clr_o      (clr_vec)
    );

    always_comb begin
        req_vec = edge_hit | sw_pulse;
        evt_req = req_vec & emask_q;
        irq_o   = pend_q & imask_q;
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_line
            lec_pulse u_pulse (
                .clk     (clk),
                .rst_n   (rst_n),
                .req_i   (evt_req[g]),
                .pulse_o (evt_pulse_o[g])
            );
        end
    endgenerate
endmodule

// File: rtl/lec_checker.sv
module lec_checker #(
    parameter int N = 19
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_vec,
    input logic [N-1:0] clr_vec,
    input logic [N-1:0] pend_q,
    input logic [N-1:0] emask_q,
    input logic [N-1:0] evt_o
);
    // R7
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~pend_q & $past(req_vec)) == '0));

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(clr_vec & ~req_vec)) == '0));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & $past(evt_o)) == '0));

    // R9
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & ~$past(req_vec & emask_q)) == '0));
endmodule

bind lec_top lec_checker #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_vec (req_vec),
    .clr_vec (clr_vec),
    .pend_q  (pend_q),
    .emask_q (emask_q),
    .evt_o   (evt_pulse_o)
);

// File: tb/sim_lec_top.sv
`timescale 1ns/1ps
module sim_lec_top;
    localparam int N = 19;
    localparam logic [N-1:0] ALL = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] line_i = '0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = 3'd0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata, irq_o, evt_pulse_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lec_top #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .evt_pulse_o(evt_pulse_o)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic move_pin(input int i, input logic val);
        @(negedge clk);
        line_i[i] = val;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [N-1:0] v, bitv, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reg reset", v, '0);
        end
        chk("R1 irq reset", irq_o, '0);
        chk("R1 evt reset", evt_pulse_o, '0);

        wr(3'd4, ALL);
        wr(3'd5, ALL);

        // R2 R3 R4 sweep: every line, every edge selection
        for (int i = 0; i < N; i++) begin
            bitv = '0; bitv[i] = 1'b1;
            for (int m = 0; m < 4; m++) begin
                wr(3'd0, m[0] ? bitv : '0);
                wr(3'd1, m[1] ? bitv : '0);
                move_pin(i, 1'b1);
                exp = m[0] ? bitv : '0;
                chk(m == 0 ? "R4 up none" : "R2 rise pending", irq_o, exp);
                chk("R9 rise pulse", evt_pulse_o, exp);
                @(negedge clk);
                chk("R9 pulse width", evt_pulse_o, '0);
                wr(3'd3, bitv);
                rd(3'd3, v);
                chk("R6 clear", v, '0);
                move_pin(i, 1'b0);
                exp = m[1] ? bitv : '0;
                chk(m == 0 ? "R4 down none" : "R3 fall pending", irq_o, exp);
                chk("R9 fall pulse", evt_pulse_o, exp);
                @(negedge clk);
                chk("R9 pulse width", evt_pulse_o, '0);
                wr(3'd3, bitv);
            end
        end

        // R7 set beats clear
        bitv = '0; bitv[5] = 1'b1;
        wr(3'd0, bitv); wr(3'd1, bitv);
        move_pin(5, 1'b1);
        chk("R7 setup", irq_o, bitv);
        @(negedge clk);
        line_i[5] = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = bitv;
        @(negedge clk);
        reg_we = 1'b0;
        rd(3'd3, v);
        chk("R7 pending kept", v, bitv);
        chk("R9 pulse on coincident", evt_pulse_o, bitv);
        wr(3'd3, 19'h0);
        rd(3'd3, v);
        chk("R6 write zero", v, bitv);
        wr(3'd3, bitv);
        rd(3'd3, v);
        chk("R6 clear after", v, '0);

        // R8 interrupt mask
        bitv = '0; bitv[2] = 1'b1;
        wr(3'd4, '0); wr(3'd0, bitv); wr(3'd1, '0);
        move_pin(2, 1'b1);
        chk("R8 masked irq", irq_o, '0);
        rd(3'd3, v);
        chk("R8 still pending", v, bitv);
        chk("R9 pulse independent of irq mask", evt_pulse_o, bitv);
        wr(3'd4, ALL);
        chk("R8 unmask shows irq", irq_o, bitv);
        wr(3'd3, bitv);
        chk("R8 irq after clear", irq_o, '0);

        // R9 event mask closed
        wr(3'd5, '0); wr(3'd1, bitv);
        move_pin(2, 1'b0);
        chk("R9 masked event", evt_pulse_o, '0);
        chk("R9 pending without event", irq_o, bitv);
        @(negedge clk);
        chk("R9 masked event later", evt_pulse_o, '0);
        wr(3'd3, bitv);
        wr(3'd5, ALL);

        // R5 software trigger on several lines
        for (int i = 0; i < N; i += 6) begin
            bitv = '0; bitv[i] = 1'b1;
            wr(3'd2, bitv);
            chk("R5 sw pending", irq_o, bitv);
            chk("R5 sw pulse", evt_pulse_o, bitv);
            rd(3'd2, v);
            chk("R5 sw readback", v, bitv);
            wr(3'd3, bitv);
            chk("R5 no second pulse", evt_pulse_o, '0);
            rd(3'd3, v);
            chk("R6 sw clears pending", v, '0);
            rd(3'd2, v);
            chk("R6 sw bit self clear", v, '0);
        end
        bitv = '0; bitv[1] = 1'b1;
        wr(3'd2, bitv);
        wr(3'd3, bitv);
        wr(3'd2, bitv);
        wr(3'd2, bitv);
        chk("R5 repeat write no request", evt_pulse_o, '0);
        wr(3'd3, bitv);
        wr(3'd3, bitv);
        rd(3'd3, v);
        chk("R5 only one request", v, '0);
        wr(3'd2, bitv);
        wr(3'd2, '0);
        rd(3'd2, v);
        chk("R5 zero write ignored", v, bitv);
        wr(3'd3, bitv);

        // R10 unused addresses
        wr(3'd0, 19'h15555);
        wr(3'd6, ALL);
        wr(3'd7, ALL);
        rd(3'd6, v);
        chk("R10 addr6 zero", v, '0);
        rd(3'd7, v);
        chk("R10 addr7 zero", v, '0);
        rd(3'd0, v);
        chk("R10 rise untouched", v, 19'h15555);
        rd(3'd3, v);
        chk("R10 pending untouched", v, '0);
        rd(3'd4, v);
        chk("R10 imask untouched", v, ALL);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule